// File: doc/BRIEF.md
# Timed Instruction Sequencer with Interrupt

This block is the control unit of a small accumulator processor with a single shared bus. A step counter walks through timing steps 0 to 6, and each step is decoded into a one-hot form. The 3-bit opcode field of the instruction word is decoded into eight one-hot lines, and the top bit of the word is captured as an indirect-address flag. From these three sources the block drives a bus source code and the load, increment, clear, read and write strobes. With these strobes the datapath fetches an instruction, decodes it, resolves an indirect address, and executes one of seven memory-reference operations.

The block also owns the interrupt state: an enable flag and a pending flag. When the pending flag is set at step 0, a three-step service cycle runs in place of the fetch. The service cycle stores the return address at address 0 and jumps to address 1. The block sees the datapath only through a few inputs: the instruction word, a flag that says the data register is zero, and the input and output ready flags. A halt instruction freezes the sequencer until reset.

Top module: `tseq_ctrl`

## Requirements
- R1: Reset puts the sequencer in this state: step_now=0, int_enable=0, int_pending=0, halted=0. While halted=0 and step_now=0, the block drives the fetch step-0 strobes.
- R2: The normal fetch has three steps. Step 0 selects bus code 2 (PC) and asserts ar_load. Step 1 asserts mem_read, selects bus code 7 (memory), and asserts ir_load and pc_incr. Step 2 selects bus code 5 (IR) and asserts ar_load, and the indirect flag takes bit 15 of the instruction word. Other bus codes: 0 is none, 1 is AR, 3 is DR, 4 is AC, 6 is TR.
- R3: At step 3, a memory-reference word (opcode bits 14:12 not equal to 7) whose indirect flag is 1 asserts mem_read and ar_load with bus code 7. If the indirect flag is 0, step 3 asserts no strobe.
- R4: Opcodes 0, 1 and 2 assert mem_read and dr_load with bus code 7 at step 4. At step 5 they assert ac_load with alu_sel 1 (AND), 2 (ADD) or 3 (load) respectively. alu_sel is 0 whenever ac_load is low.
- R5: At step 4, opcode 3 asserts mem_write with bus code 4, and opcode 4 asserts pc_load with bus code 1.
- R6: Opcode 5 asserts mem_write and ar_incr with bus code 2 at step 4. At step 5 it asserts pc_load with bus code 1.
- R7: Opcode 6 asserts mem_read and dr_load with bus code 7 at step 4 and dr_incr at step 5. At step 6 it asserts mem_write with bus code 3, and also pc_incr when dr_is_zero is 1.
- R8: After the last step of each operation, step_now returns to 0. The last steps are: 5 for opcodes 0, 1, 2 and 5; 4 for opcodes 3 and 4; 6 for opcode 6; 3 for opcode 7. step_now never exceeds 6.
- R9: At step 3, a word with bit 15 set and opcode 7 sets int_enable if bit 7 is 1 and clears int_enable if bit 6 is 1.
- R10: int_pending is set at a clock edge only when all three hold: step_now is 3 or more, int_enable is 1, and in_flag or out_flag is 1.
- R11: When int_pending is 1 at step 0, the service cycle runs. Step 0 asserts ar_clear and tr_load with bus code 2. Step 1 asserts mem_write and pc_clear with bus code 6. Step 2 asserts pc_incr, and after it int_enable, int_pending and step_now are all 0.
- R12: At step 3, a word with bit 15 clear, opcode 7 and bit 0 set makes halted 1. While halted is 1, step_now stays 0, every strobe is low, bus code is 0 and int_pending does not change. This lasts until reset.
- R13: mem_read and mem_write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_word | input | 16 | Current instruction register contents |
| dr_is_zero | input | 1 | Data register equals zero |
| in_flag | input | 1 | Input character ready |
| out_flag | input | 1 | Output device ready |
| bus_sel | output | 3 | Bus source code |
| ar_load | output | 1 | Load AR from bus |
| ar_incr | output | 1 | Increment AR |
| ar_clear | output | 1 | Clear AR |
| pc_load | output | 1 | Load PC from bus |
| pc_incr | output | 1 | Increment PC |
| pc_clear | output | 1 | Clear PC |
| dr_load | output | 1 | Load DR from bus |
| dr_incr | output | 1 | Increment DR |
| ac_load | output | 1 | Load AC from ALU |
| alu_sel | output | 2 | ALU function for ac_load |
| ir_load | output | 1 | Load IR from bus |
| tr_load | output | 1 | Load TR from bus |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write from bus |
| step_now | output | 3 | Current timing step |
| int_enable | output | 1 | Interrupt enable flag |
| int_pending | output | 1 | Interrupt pending flag |
| halted | output | 1 | Sequencer stopped |

## Verification
The bench builds the block with its default parameters: a 16-bit instruction word, a 3-bit opcode field at bit 12, and seven timing steps. With these values every one of the eight opcode lines can be reached, and so can the longest path, the step-6 write-back of opcode 6, where the skip depends on dr_is_zero. The bench plays the datapath by hand: it presents the instruction word after the fetch load, and it drives the flags so that the pending flag must wait for step 3. It then walks through the service cycle, the enable and disable words, and the halt freeze.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
package tseq_pkg;

    localparam int HLT_BIT = 0;
    localparam int ION_BIT = 7;
    localparam int IOF_BIT = 6;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_AND  = 2'd1,
        ALU_ADD  = 2'd2,
        ALU_PASS = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic     ar_ld;
        logic     ar_inc;
        logic     ar_clr;
        logic     pc_ld;
        logic     pc_inc;
        logic     pc_clr;
        logic     dr_ld;
        logic     dr_inc;
        logic     ac_ld;
        logic     ir_ld;
        logic     tr_ld;
        logic     mem_rd;
        logic     mem_wr;
        alu_op_e  alu;
        bus_src_e bus;
    } ctl_strobe_t;

endpackage

// File: rtl/tseq_step_counter.sv
`timescale 1ns/1ps
module tseq_step_counter #(
    parameter int NUM_STEPS = 7,
    localparam int STEP_W   = $clog2(NUM_STEPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    input  logic                 clear,
    output logic [STEP_W-1:0]    step_cnt,
    output logic [NUM_STEPS-1:0] step_hot
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            step_cnt <= '0;
        end else if (advance) begin
            step_cnt <= step_cnt + STEP_W'(1);
        end
    end

    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_hot
        assign step_hot[k] = (step_cnt == STEP_W'(k));
    end

endmodule

// File: rtl/tseq_op_decoder.sv
`timescale 1ns/1ps
module tseq_op_decoder #(
    parameter int OPC_W   = 3,
    localparam int NUM_OP = 2 ** OPC_W
) (
    input  logic [OPC_W-1:0]  opc,
    output logic [NUM_OP-1:0] op_hot
);

    for (genvar k = 0; k < NUM_OP; k++) begin : g_dec
        assign op_hot[k] = (opc == OPC_W'(k));
    end

endmodule

// File: rtl/tseq_irq_unit.sv
`timescale 1ns/1ps
module tseq_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic en_set,
    input  logic en_clr,
    input  logic svc_done,
    input  logic arm_window,
    input  logic flag_any,
    output logic ien_q,
    output logic pend_q
);

    always_ff @(posedge clk) begin
        if (rst || svc_done || en_clr) begin
            ien_q <= 1'b0;
        end else if (en_set) begin
            ien_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || svc_done) begin
            pend_q <= 1'b0;
        end else if (arm_window && ien_q && flag_any) begin
            pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/tseq_ctrl.sv
`timescale 1ns/1ps
module tseq_ctrl
    import tseq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int OPC_LSB   = 12,
    parameter int OPC_W     = 3,
    parameter int NUM_STEPS = 7,
    localparam int STEP_W   = $clog2(NUM_STEPS),
    localparam int NUM_OP   = 2 ** OPC_W,
    localparam int IND_BIT  = WORD_W - 1,
    localparam int REG_OP   = NUM_OP - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ir_word,
    input  logic              dr_is_zero,
    input  logic              in_flag,
    input  logic              out_flag,
    output logic [2:0]        bus_sel,
    output logic              ar_load,
    output logic              ar_incr,
    output logic              ar_clear,
    output logic              pc_load,
    output logic              pc_incr,
    output logic              pc_clear,
    output logic              dr_load,
    output logic              dr_incr,
    output logic              ac_load,
    output logic [1:0]        alu_sel,
    output logic              ir_load,
    output logic              tr_load,
    output logic              mem_read,
    output logic              mem_write,
    output logic [STEP_W-1:0] step_now,
    output logic              int_enable,
    output logic              int_pending,
    output logic              halted
);

    logic [NUM_STEPS-1:0] t;
    logic [NUM_OP-1:0]    d;
    logic                 ind_q;
    logic                 halt_q;
    logic                 end_cycle;
    logic                 halt_set;
    logic                 ion_hit;
    logic                 iof_hit;
    logic                 svc_done;
    logic                 regop_t3;
    ctl_strobe_t          st;
    wire                  unused_ir = ^ir_word;

    tseq_step_counter #(.NUM_STEPS(NUM_STEPS)) u_sc (
        .clk      (clk),
        .rst      (rst),
        .advance  (!halt_q),
        .clear    (end_cycle),
        .step_cnt (step_now),
        .step_hot (t)
    );

    tseq_op_decoder #(.OPC_W(OPC_W)) u_dec (
        .opc    (ir_word[OPC_LSB +: OPC_W]),
        .op_hot (d)
    );

    tseq_irq_unit u_irq (
        .clk        (clk),
        .rst        (rst),
        .en_set     (ion_hit),
        .en_clr     (iof_hit),
        .svc_done   (svc_done),
        .arm_window (!halt_q && !(t[0] || t[1] || t[2])),
        .flag_any   (in_flag || out_flag),
        .ien_q      (int_enable),
        .pend_q     (int_pending)
    );

    assign regop_t3 = !halt_q && t[3] && d[REG_OP];
    assign ion_hit  = regop_t3 && ir_word[IND_BIT] && ir_word[ION_BIT];
    assign iof_hit  = regop_t3 && ir_word[IND_BIT] && ir_word[IOF_BIT];
    assign halt_set = regop_t3 && !ir_word[IND_BIT] && ir_word[HLT_BIT];
    assign svc_done = !halt_q && t[2] && int_pending;

    assign end_cycle = !halt_q && (svc_done || regop_t3
                     || (t[4] && (d[3] || d[4]))
                     || (t[5] && (d[0] || d[1] || d[2] || d[5]))
                     || (t[6] && d[6]));

    always_ff @(posedge clk) begin
        if (rst) begin
            ind_q  <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (!halt_q && t[2] && !int_pending) begin
                ind_q <= ir_word[IND_BIT];
            end
            if (halt_set) begin
                halt_q <= 1'b1;
            end
        end
    end

    always_comb begin
        st = '0;
        if (!halt_q) begin
            if (t[0]) begin
                st.bus = BUS_PC;
                if (int_pending) begin
                    st.ar_clr = 1'b1;
                    st.tr_ld  = 1'b1;
                end else begin
                    st.ar_ld  = 1'b1;
                end
            end
            if (t[1]) begin
                if (int_pending) begin
                    st.bus    = BUS_TR;
                    st.mem_wr = 1'b1;
                    st.pc_clr = 1'b1;
                end else begin
                    st.bus    = BUS_MEM;
                    st.mem_rd = 1'b1;
                    st.ir_ld  = 1'b1;
                    st.pc_inc = 1'b1;
                end
            end
            if (t[2]) begin
                if (int_pending) begin
                    st.pc_inc = 1'b1;
                end else begin
                    st.bus   = BUS_IR;
                    st.ar_ld = 1'b1;
                end
            end
            if (t[3] && !d[REG_OP] && ind_q) begin
                st.bus    = BUS_MEM;
                st.mem_rd = 1'b1;
                st.ar_ld  = 1'b1;
            end
            if (t[4]) begin
                if (d[0] || d[1] || d[2] || d[6]) begin
                    st.bus    = BUS_MEM;
                    st.mem_rd = 1'b1;
                    st.dr_ld  = 1'b1;
                end
                if (d[3]) begin
                    st.bus    = BUS_AC;
                    st.mem_wr = 1'b1;
                end
                if (d[4]) begin
                    st.bus   = BUS_AR;
                    st.pc_ld = 1'b1;
                end
                if (d[5]) begin
                    st.bus    = BUS_PC;
                    st.mem_wr = 1'b1;
                    st.ar_inc = 1'b1;
                end
            end
            if (t[5]) begin
                if (d[0]) begin st.ac_ld = 1'b1; st.alu = ALU_AND;  end
                if (d[1]) begin st.ac_ld = 1'b1; st.alu = ALU_ADD;  end
                if (d[2]) begin st.ac_ld = 1'b1; st.alu = ALU_PASS; end
                if (d[5]) begin
                    st.bus   = BUS_AR;
                    st.pc_ld = 1'b1;
                end
                if (d[6]) begin
                    st.dr_inc = 1'b1;
                end
            end
            if (t[6] && d[6]) begin
                st.bus    = BUS_DR;
                st.mem_wr = 1'b1;
                st.pc_inc = dr_is_zero;
            end
        end
    end

    assign bus_sel   = st.bus;
    assign ar_load   = st.ar_ld;
    assign ar_incr   = st.ar_inc;
    assign ar_clear  = st.ar_clr;
    assign pc_load   = st.pc_ld;
    assign pc_incr   = st.pc_inc;
    assign pc_clear  = st.pc_clr;
    assign dr_load   = st.dr_ld;
    assign dr_incr   = st.dr_inc;
    assign ac_load   = st.ac_ld;
    assign alu_sel   = st.alu;
    assign ir_load   = st.ir_ld;
    assign tr_load   = st.tr_ld;
    assign mem_read  = st.mem_rd;
    assign mem_write = st.mem_wr;
    assign halted    = halt_q;

endmodule

// File: rtl/tseq_ctrl_chk.sv
`timescale 1ns/1ps
module tseq_ctrl_chk #(
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_read,
    input logic              mem_write,
    input logic [STEP_W-1:0] step_now,
    input logic              int_enable,
    input logic              int_pending,
    input logic              halted
);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_read, mem_write}));  // R13

    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!halted && step_now == 0) |=> (step_now == 1));  // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        step_now <= 6);  // R8

    AST_PEND_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(int_pending) |-> ($past(int_enable) && $past(step_now) >= 3));  // R10

    AST_SERVICE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (int_pending && step_now == 2) |=> (!int_pending && !int_enable && step_now == 0));  // R11

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(step_now) && $stable(int_pending)));  // R12

endmodule

bind tseq_ctrl tseq_ctrl_chk #(.STEP_W(STEP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_read    (mem_read),
    .mem_write   (mem_write),
    .step_now    (step_now),
    .int_enable  (int_enable),
    .int_pending (int_pending),
    .halted      (halted)
);

// File: tb/tseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module tseq_ctrl_tb_top;

    localparam logic [12:0] M_ARLD  = 13'h1000;
    localparam logic [12:0] M_ARINC = 13'h0800;
    localparam logic [12:0] M_ARCLR = 13'h0400;
    localparam logic [12:0] M_PCLD  = 13'h0200;
    localparam logic [12:0] M_PCINC = 13'h0100;
    localparam logic [12:0] M_PCCLR = 13'h0080;
    localparam logic [12:0] M_DRLD  = 13'h0040;
    localparam logic [12:0] M_DRINC = 13'h0020;
    localparam logic [12:0] M_ACLD  = 13'h0010;
    localparam logic [12:0] M_IRLD  = 13'h0008;
    localparam logic [12:0] M_TRLD  = 13'h0004;
    localparam logic [12:0] M_RD    = 13'h0002;
    localparam logic [12:0] M_WR    = 13'h0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir_word = 16'h0000;
    logic        dr_is_zero = 1'b0;
    logic        in_flag = 1'b0;
    logic        out_flag = 1'b0;
    logic [2:0]  bus_sel;
    logic        ar_load, ar_incr, ar_clear, pc_load, pc_incr, pc_clear;
    logic        dr_load, dr_incr, ac_load, ir_load, tr_load, mem_read, mem_write;
    logic [1:0]  alu_sel;
    logic [2:0]  step_now;
    logic        int_enable, int_pending, halted;
    int          n_chk = 0;
    int          n_bad = 0;

    wire [12:0] act = {ar_load, ar_incr, ar_clear, pc_load, pc_incr, pc_clear,
                       dr_load, dr_incr, ac_load, ir_load, tr_load, mem_read, mem_write};

    always #5 clk = ~clk;

    tseq_ctrl dut_i (
        .clk(clk), .rst(rst), .ir_word(ir_word), .dr_is_zero(dr_is_zero),
        .in_flag(in_flag), .out_flag(out_flag), .bus_sel(bus_sel),
        .ar_load(ar_load), .ar_incr(ar_incr), .ar_clear(ar_clear),
        .pc_load(pc_load), .pc_incr(pc_incr), .pc_clear(pc_clear),
        .dr_load(dr_load), .dr_incr(dr_incr), .ac_load(ac_load), .alu_sel(alu_sel),
        .ir_load(ir_load), .tr_load(tr_load), .mem_read(mem_read), .mem_write(mem_write),
        .step_now(step_now), .int_enable(int_enable), .int_pending(int_pending),
        .halted(halted)
    );

    task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic expect_now(input string req, input logic [2:0] bus,
                              input logic [12:0] m, input logic [1:0] alu);
        chk({req, " bus"}, 32'(bus_sel), 32'(bus));
        chk({req, " strobes"}, 32'(act), 32'(m));
        chk({req, " alu"}, 32'(alu_sel), 32'(alu));
        chk("R13 rd/wr exclusive", 32'(mem_read & mem_write), 32'd0);
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // positioned mid step 0; leaves positioned mid step 3
    task automatic fetch(input logic [15:0] w);
        chk("R2 step0", 32'(step_now), 32'd0);
        expect_now("R2 fetch t0", 3'd2, M_ARLD, 2'd0);
        tick();
        expect_now("R2 fetch t1", 3'd7, M_RD | M_IRLD | M_PCINC, 2'd0);
        ir_word = w;
        tick();
        expect_now("R2 fetch t2", 3'd5, M_ARLD, 2'd0);
        tick();
    endtask

    task automatic back_to_t0(input string req);
        tick();
        chk(req, 32'(step_now), 32'd0);
    endtask

    task automatic t_acc(input logic [15:0] w, input logic [1:0] alu);
        fetch(w);
        if (w[15]) expect_now("R3 indirect t3", 3'd7, M_RD | M_ARLD, 2'd0);
        else       expect_now("R3 direct t3", 3'd0, 13'd0, 2'd0);
        tick();
        expect_now("R4 operand read t4", 3'd7, M_RD | M_DRLD, 2'd0);
        tick();
        expect_now("R4 ac update t5", 3'd0, M_ACLD, alu);
        back_to_t0("R8 end after t5");
    endtask

    task automatic t_store_branch();
        fetch(16'h3045);
        expect_now("R3 direct t3", 3'd0, 13'd0, 2'd0);
        tick();
        expect_now("R5 store t4", 3'd4, M_WR, 2'd0);
        back_to_t0("R8 store ends t4");
        fetch(16'h4010);
        tick();
        expect_now("R5 branch t4", 3'd1, M_PCLD, 2'd0);
        back_to_t0("R8 branch ends t4");
    endtask

    task automatic t_call();
        fetch(16'h5020);
        tick();
        expect_now("R6 call t4", 3'd2, M_WR | M_ARINC, 2'd0);
        tick();
        expect_now("R6 call t5", 3'd1, M_PCLD, 2'd0);
        back_to_t0("R8 call ends t5");
    endtask

    task automatic t_isz(input logic zero);
        fetch(16'h6030);
        tick();
        expect_now("R7 isz t4", 3'd7, M_RD | M_DRLD, 2'd0);
        tick();
        expect_now("R7 isz t5", 3'd0, M_DRINC, 2'd0);
        dr_is_zero = zero;
        tick();
        expect_now("R7 isz t6", 3'd3, M_WR | (zero ? M_PCINC : 13'd0), 2'd0);
        dr_is_zero = 1'b0;
        back_to_t0("R8 isz ends t6");
    endtask

    task automatic t_io(input logic [15:0] w);
        fetch(w);
        expect_now("R9 io t3", 3'd0, 13'd0, 2'd0);
        back_to_t0("R8 io ends t3");
    endtask

    task automatic t_interrupt();
        t_io(16'hF080);
        chk("R9 enable set", 32'(int_enable), 32'd1);
        t_store_branch();
        chk("R10 no pend without flag", 32'(int_pending), 32'd0);
        out_flag = 1'b1;
        fetch(16'h3045);
        chk("R10 not set in t0-t2", 32'(int_pending), 32'd0);
        tick();
        chk("R10 set after t3", 32'(int_pending), 32'd1);
        back_to_t0("R8 store ends t4");
        expect_now("R11 svc t0", 3'd2, M_ARCLR | M_TRLD, 2'd0);
        tick();
        expect_now("R11 svc t1", 3'd6, M_WR | M_PCCLR, 2'd0);
        tick();
        expect_now("R11 svc t2", 3'd0, M_PCINC, 2'd0);
        back_to_t0("R11 step cleared");
        chk("R11 enable cleared", 32'(int_enable), 32'd0);
        chk("R11 pending cleared", 32'(int_pending), 32'd0);
        expect_now("R11 normal fetch resumes", 3'd2, M_ARLD, 2'd0);
        out_flag = 1'b0;
        t_io(16'hF080);
        chk("R9 enable set again", 32'(int_enable), 32'd1);
        t_io(16'hF040);
        chk("R9 enable cleared by disable word", 32'(int_enable), 32'd0);
    endtask

    task automatic t_halt();
        t_io(16'hF080);
        fetch(16'h7001);
        tick();
        chk("R12 halted", 32'(halted), 32'd1);
        in_flag = 1'b1;
        for (int k = 0; k < 5; k++) begin
            chk("R12 step frozen", 32'(step_now), 32'd0);
            expect_now("R12 no strobes", 3'd0, 13'd0, 2'd0);
            chk("R12 pending frozen", 32'(int_pending), 32'd0);
            tick();
        end
        in_flag = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk("R1 step", 32'(step_now), 32'd0);
        chk("R1 enable", 32'(int_enable), 32'd0);
        chk("R1 pending", 32'(int_pending), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);
        expect_now("R1 fetch t0", 3'd2, M_ARLD, 2'd0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_acc(16'h0123, 2'd1);
        t_acc(16'h9123, 2'd2);
        t_acc(16'h2040, 2'd3);
        t_store_branch();
        t_call();
        t_isz(1'b0);
        t_isz(1'b1);
        t_interrupt();
        t_halt();
        t_reset();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule